// File: doc/BRIEF.md
# UART Receive-Error and Transmit-End Status Flags

This block keeps the two sticky status flags of a FIFO-buffered UART. One flag reports a bad received character and the other reports that the transmitter has gone idle. The receiver sends a strobe when a character's data and parity have been assembled, and a further strobe for each stop-bit sample. The block holds the character until the first stop sample that follows it. It then checks framing and parity and passes the byte, tagged with its own framing and parity error bits, to the receive FIFO. Stop samples after that first one are ignored, so a two-stop-bit frame is judged on its first stop bit only.

Software reads both flags through a small register port. The error flag clears only by a read that returns 1 followed by a write of 0 to that bit. A new error in the same cycle as such a write keeps the flag set. The transmit-end flag follows the transmitter. It is set when the last bit of a character leaves while the transmit FIFO is empty, when the transmitter is disabled, or when standby is entered. It clears when the transmit FIFO is written. Shift registers, baud timing and the FIFOs are outside this block.

Top module: `uart_status_ctl`

## Requirements
- R1: A committed character whose first stop sample (`rx_stop_bit_i`) is 0 sets `rx_err_o` at the next clock edge and is tagged with framing error bit 1.
- R2: With `par_en_i`=1, the count of 1s over `rx_data_i` plus `rx_par_bit_i` must be even when `par_odd_i`=0 and odd when `par_odd_i`=1. A mismatch sets `rx_err_o` and the parity error tag. With `par_en_i`=0 the parity tag is 0.
- R3: Only the first stop strobe after a character strobe commits the character. Later stop strobes cause no FIFO write and leave `rx_err_o` unchanged, whatever their value.
- R4: A write of 0 to the error bit clears `rx_err_o` only if a read that returned it as 1 came after the previous write. A write of 1 has no effect, and any write consumes the earlier read.
- R5: If an error is committed in the same cycle as a clearing write, `rx_err_o` ends set.
- R6: While `rx_en_i`=0, character and stop strobes are discarded (no FIFO write) and `rx_err_o` keeps its value.
- R7: Every committed character, errored or not, pulses `rxf_wr_o` for one cycle one edge after its stop strobe. `rxf_word_o` then holds parity error at bit DATA_W+1, framing error at bit DATA_W and the data in bits DATA_W-1:0. The next character is received normally.
- R8: After reset, `rx_err_o`=0, `tx_end_o`=1 and `rxf_wr_o`=0.
- R9: `standby_i`=1 clears `rx_err_o`, sets `tx_end_o` and discards a pending read-arm, and it wins over any event in the same cycle.
- R10: `tx_last_bit_i` with `txf_empty_i`=1 sets `tx_end_o`. With `txf_empty_i`=0 the flag is not set.
- R11: `txf_wr_i` clears `tx_end_o`. `tx_en_i`=0 sets it, and any set condition wins over a simultaneous write.
- R12: `reg_rdata_o` bit 0 is the receive-error flag and bit 1 is the transmit-end flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| standby_i | input | 1 | Standby entry |
| rx_en_i | input | 1 | Receiver enable |
| rx_char_stb_i | input | 1 | Character data and parity valid |
| rx_data_i | input | DATA_W | Received data bits |
| rx_par_bit_i | input | 1 | Received parity bit |
| par_en_i | input | 1 | Parity checking enabled |
| par_odd_i | input | 1 | 1 = odd parity, 0 = even |
| rx_stop_stb_i | input | 1 | Stop-bit sample valid |
| rx_stop_bit_i | input | 1 | Stop-bit sample value |
| tx_en_i | input | 1 | Transmitter enable |
| tx_last_bit_i | input | 1 | Last bit of a character sent |
| txf_empty_i | input | 1 | Transmit FIFO holds no data |
| txf_wr_i | input | 1 | Transmit FIFO written |
| reg_rd_i | input | 1 | Status register read strobe |
| reg_wr_i | input | 1 | Status register write strobe |
| reg_wdata_i | input | 1 | Value written to the error bit |
| reg_rdata_o | output | 2 | Status read data |
| rx_err_o | output | 1 | Receive-error flag |
| tx_end_o | output | 1 | Transmit-end flag |
| rxf_wr_o | output | 1 | Receive FIFO write |
| rxf_word_o | output | DATA_W+2 | Tagged byte for the receive FIFO |

## Verification
A table of characters covers even, odd and disabled parity with clean and failing counts of 1s, a first stop bit of 1 and of 0, and a following stop sample of both values. This separates the framing tag, the parity tag and the ignored second stop sample within a single flag update. Directed sequences then try writes of 0 and 1 with and without a preceding read, a clear that coincides with a new error, disabled reception, and standby after an arming read. They also drive transmit FIFO writes against last-bit events with the FIFO full and empty, and against a disabled transmitter. Each of these shows which event wins when set and clear meet.

// File: rtl/uart_stat_pkg.sv
package uart_stat_pkg;
  localparam int STAT_W    = 2;
  localparam int RXERR_BIT = 0;
  localparam int TXEND_BIT = 1;

  typedef struct packed {
    logic per;
    logic fer;
  } rx_tag_t;

  typedef enum logic {
    ARM_IDLE = 1'b0,
    ARM_SET  = 1'b1
  } arm_e;
endpackage

// File: rtl/uart_stat_rst_sync.sv
module uart_stat_rst_sync (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) sync_q <= 2'b00;
    else          sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_o = sync_q[1];
endmodule

// File: rtl/uart_rx_err_track.sv
module uart_rx_err_track
  import uart_stat_pkg::*;
#(
  parameter  int DATA_W = 8,
  localparam int WORD_W = DATA_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              standby_i,
  input  logic              rx_en_i,
  input  logic              char_stb_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              par_bit_i,
  input  logic              par_en_i,
  input  logic              par_odd_i,
  input  logic              stop_stb_i,
  input  logic              stop_bit_i,
  input  logic              clr_req_i,
  output logic              rx_err_o,
  output logic              fifo_wr_o,
  output logic [WORD_W-1:0] fifo_word_o
);
  logic              pend_q, pend_d;
  logic [DATA_W-1:0] dat_q;
  logic              per_q, per_d;
  logic              err_q, err_d;
  logic              wr_q, wr_d;
  logic [WORD_W-1:0] word_q, word_d;
  logic              char_ok, commit, word_en;
  rx_tag_t           tag;

  // next-state logic
  always_comb begin
    char_ok = rx_en_i & char_stb_i & ~standby_i;
    commit  = rx_en_i & stop_stb_i & pend_q & ~standby_i;
    tag.fer = ~stop_bit_i;
    tag.per = per_q;

    per_d = par_en_i & ((^{data_i, par_bit_i}) ^ par_odd_i);

    if (standby_i || !rx_en_i) pend_d = 1'b0;
    else if (char_ok)          pend_d = 1'b1;
    else if (commit)           pend_d = 1'b0;
    else                       pend_d = pend_q;

    wr_d    = commit;
    word_en = commit;
    word_d  = {tag, dat_q};

    if (standby_i)                       err_d = 1'b0;
    else if (commit && (tag.fer | tag.per)) err_d = 1'b1;
    else if (clr_req_i)                  err_d = 1'b0;
    else                                 err_d = err_q;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      dat_q  <= '0;
      per_q  <= 1'b0;
      err_q  <= 1'b0;
      wr_q   <= 1'b0;
      word_q <= '0;
    end else begin
      pend_q <= pend_d;
      err_q  <= err_d;
      wr_q   <= wr_d;
      if (char_ok) begin
        dat_q <= data_i;
        per_q <= per_d;
      end
      if (word_en) word_q <= word_d;
    end
  end

  assign rx_err_o    = err_q;
  assign fifo_wr_o   = wr_q;
  assign fifo_word_o = word_q;
endmodule

// File: rtl/uart_tx_end_track.sv
module uart_tx_end_track (
  input  logic clk,
  input  logic rst_n,
  input  logic standby_i,
  input  logic tx_en_i,
  input  logic last_bit_i,
  input  logic fifo_empty_i,
  input  logic fifo_wr_i,
  output logic tx_end_o
);
  logic end_q, end_d;
  logic set_evt;

  always_comb begin
    set_evt = standby_i | ~tx_en_i | (last_bit_i & fifo_empty_i);
    if (set_evt)        end_d = 1'b1;
    else if (fifo_wr_i) end_d = 1'b0;
    else                end_d = end_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) end_q <= 1'b1;
    else        end_q <= end_d;
  end

  assign tx_end_o = end_q;
endmodule

// File: rtl/uart_stat_regif.sv
module uart_stat_regif
  import uart_stat_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              standby_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic              wdata_i,
  input  logic              rx_err_i,
  input  logic              tx_end_i,
  output logic [STAT_W-1:0] rdata_o,
  output logic              rx_clr_o
);
  arm_e arm_q, arm_d;

  always_comb begin
    rdata_o            = '0;
    rdata_o[RXERR_BIT] = rx_err_i;
    rdata_o[TXEND_BIT] = tx_end_i;

    rx_clr_o = wr_i & (arm_q == ARM_SET) & ~wdata_i;

    arm_d = arm_q;
    if (wr_i)             arm_d = ARM_IDLE;
    if (rd_i && rx_err_i) arm_d = ARM_SET;
    if (standby_i)        arm_d = ARM_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) arm_q <= ARM_IDLE;
    else        arm_q <= arm_d;
  end
endmodule

// File: rtl/uart_status_ctl.sv
module uart_status_ctl
  import uart_stat_pkg::*;
#(
  parameter  int DATA_W = 8,
  localparam int WORD_W = DATA_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              standby_i,
  input  logic              rx_en_i,
  input  logic              rx_char_stb_i,
  input  logic [DATA_W-1:0] rx_data_i,
  input  logic              rx_par_bit_i,
  input  logic              par_en_i,
  input  logic              par_odd_i,
  input  logic              rx_stop_stb_i,
  input  logic              rx_stop_bit_i,
  input  logic              tx_en_i,
  input  logic              tx_last_bit_i,
  input  logic              txf_empty_i,
  input  logic              txf_wr_i,
  input  logic              reg_rd_i,
  input  logic              reg_wr_i,
  input  logic              reg_wdata_i,
  output logic [STAT_W-1:0] reg_rdata_o,
  output logic              rx_err_o,
  output logic              tx_end_o,
  output logic              rxf_wr_o,
  output logic [WORD_W-1:0] rxf_word_o
);
  logic rst_n_s;
  logic rx_clr;

  uart_stat_rst_sync u_rst (
    .clk     (clk),
    .rst_n_i (rst_n),
    .rst_n_o (rst_n_s)
  );

  uart_rx_err_track #(.DATA_W(DATA_W)) u_rx (
    .clk         (clk),
    .rst_n       (rst_n_s),
    .standby_i   (standby_i),
    .rx_en_i     (rx_en_i),
    .char_stb_i  (rx_char_stb_i),
    .data_i      (rx_data_i),
    .par_bit_i   (rx_par_bit_i),
    .par_en_i    (par_en_i),
    .par_odd_i   (par_odd_i),
    .stop_stb_i  (rx_stop_stb_i),
    .stop_bit_i  (rx_stop_bit_i),
    .clr_req_i   (rx_clr),
    .rx_err_o    (rx_err_o),
    .fifo_wr_o   (rxf_wr_o),
    .fifo_word_o (rxf_word_o)
  );

  uart_tx_end_track u_tx (
    .clk          (clk),
    .rst_n        (rst_n_s),
    .standby_i    (standby_i),
    .tx_en_i      (tx_en_i),
    .last_bit_i   (tx_last_bit_i),
    .fifo_empty_i (txf_empty_i),
    .fifo_wr_i    (txf_wr_i),
    .tx_end_o     (tx_end_o)
  );

  uart_stat_regif u_reg (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .standby_i (standby_i),
    .rd_i      (reg_rd_i),
    .wr_i      (reg_wr_i),
    .wdata_i   (reg_wdata_i),
    .rx_err_i  (rx_err_o),
    .tx_end_i  (tx_end_o),
    .rdata_o   (reg_rdata_o),
    .rx_clr_o  (rx_clr)
  );
endmodule

// File: rtl/uart_status_ctl_chk.sv
module uart_status_ctl_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              standby_i,
  input logic              rx_stop_stb_i,
  input logic              tx_en_i,
  input logic              tx_last_bit_i,
  input logic              txf_empty_i,
  input logic              txf_wr_i,
  input logic              reg_wr_i,
  input logic              reg_wdata_i,
  input logic              rx_err_o,
  input logic              tx_end_o,
  input logic              rxf_wr_o,
  input logic [DATA_W+1:0] rxf_word_o
);
  AST_STANDBY_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    standby_i |=> (!rx_err_o && tx_end_o)); // R9
  AST_TXEND_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_last_bit_i && txf_empty_i) |=> tx_end_o); // R10
  AST_TXEND_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (txf_wr_i && tx_en_i && !standby_i && !(tx_last_bit_i && txf_empty_i)) |=> !tx_end_o); // R11
  AST_TXEN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en_i |=> tx_end_o); // R11
  AST_WRITE_ONE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_err_o && reg_wr_i && reg_wdata_i && !standby_i) |=> rx_err_o); // R4
  AST_ERR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_err_o && !reg_wr_i && !standby_i) |=> rx_err_o); // R4
  AST_TAG_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    (rxf_wr_o && (rxf_word_o[DATA_W] || rxf_word_o[DATA_W+1])) |-> rx_err_o); // R7
  AST_WRITE_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    rxf_wr_o |-> $past(rx_stop_stb_i)); // R7
endmodule

bind uart_status_ctl uart_status_ctl_chk #(.DATA_W(DATA_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .standby_i     (standby_i),
  .rx_stop_stb_i (rx_stop_stb_i),
  .tx_en_i       (tx_en_i),
  .tx_last_bit_i (tx_last_bit_i),
  .txf_empty_i   (txf_empty_i),
  .txf_wr_i      (txf_wr_i),
  .reg_wr_i      (reg_wr_i),
  .reg_wdata_i   (reg_wdata_i),
  .rx_err_o      (rx_err_o),
  .tx_end_o      (tx_end_o),
  .rxf_wr_o      (rxf_wr_o),
  .rxf_word_o    (rxf_word_o)
);

// File: tb/tb_uart_status_ctl.sv
`timescale 1ns/1ps
module tb_uart_status_ctl;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst_n, standby, rx_en, char_stb, par_bit, par_en, par_odd;
  logic stop_stb, stop_bit, tx_en, tx_last, txf_empty, txf_wr;
  logic reg_rd, reg_wr, reg_wdata;
  logic [DW-1:0] data;
  logic [1:0]    rdata;
  logic          rx_err, tx_end, rxf_wr;
  logic [DW+1:0] rxf_word;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  uart_status_ctl #(.DATA_W(DW)) dut (
    .clk(clk), .rst_n(rst_n), .standby_i(standby), .rx_en_i(rx_en),
    .rx_char_stb_i(char_stb), .rx_data_i(data), .rx_par_bit_i(par_bit),
    .par_en_i(par_en), .par_odd_i(par_odd), .rx_stop_stb_i(stop_stb),
    .rx_stop_bit_i(stop_bit), .tx_en_i(tx_en), .tx_last_bit_i(tx_last),
    .txf_empty_i(txf_empty), .txf_wr_i(txf_wr), .reg_rd_i(reg_rd),
    .reg_wr_i(reg_wr), .reg_wdata_i(reg_wdata), .reg_rdata_o(rdata),
    .rx_err_o(rx_err), .tx_end_o(tx_end), .rxf_wr_o(rxf_wr),
    .rxf_word_o(rxf_word)
  );

  // {data[7:0], par, stop1, stop2, par_en, par_odd, exp_fer, exp_per}
  localparam logic [14:0] VEC [8] = '{
    {8'h55, 7'b0111000},
    {8'h55, 7'b1111001},
    {8'h55, 7'b1111100},
    {8'h07, 7'b0011110},
    {8'h07, 7'b0011011},
    {8'hFF, 7'b1100000},
    {8'h00, 7'b0111101},
    {8'h80, 7'b0100000}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic send_char(input logic [DW-1:0] d, input logic p);
    char_stb = 1'b1; data = d; par_bit = p;
    tick();
    char_stb = 1'b0;
  endtask

  task automatic send_stop(input logic b);
    stop_stb = 1'b1; stop_bit = b;
    tick();
    stop_stb = 1'b0;
  endtask

  task automatic do_read(output logic [1:0] v);
    reg_rd = 1'b1;
    v = rdata;
    tick();
    reg_rd = 1'b0;
  endtask

  task automatic do_write(input logic v);
    reg_wr = 1'b1; reg_wdata = v;
    tick();
    reg_wr = 1'b0;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      finish_run();
    end
  end

  initial begin
    logic [1:0] rv;
    logic exp_err;
    rst_n = 1'b0; standby = 1'b0; rx_en = 1'b1; char_stb = 1'b0; data = '0;
    par_bit = 1'b0; par_en = 1'b0; par_odd = 1'b0; stop_stb = 1'b0; stop_bit = 1'b1;
    tx_en = 1'b1; tx_last = 1'b0; txf_empty = 1'b1; txf_wr = 1'b0;
    reg_rd = 1'b0; reg_wr = 1'b0; reg_wdata = 1'b0;
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (4) tick();

    // R8 / R12 reset state
    chk("R8 rx_err reset", rx_err, 0);
    chk("R8 tx_end reset", tx_end, 1);
    chk("R8 rxf_wr reset", rxf_wr, 0);
    chk("R12 rdata reset", rdata, 2'b10);

    // R1 R2 R3 R7 vector table
    exp_err = 1'b0;
    for (int i = 0; i < 8; i++) begin
      par_en  = VEC[i][3];
      par_odd = VEC[i][2];
      send_char(VEC[i][14:7], VEC[i][6]);
      send_stop(VEC[i][5]);
      exp_err = exp_err | VEC[i][1] | VEC[i][0];
      chk("R7 fifo write", rxf_wr, 1);
      chk("R1 R2 R7 tagged word", rxf_word, {VEC[i][0], VEC[i][1], VEC[i][14:7]});
      chk("R1 R2 flag", rx_err, exp_err);
      send_stop(VEC[i][4]);
      chk("R3 second stop no write", rxf_wr, 0);
      chk("R3 second stop flag", rx_err, exp_err);
    end

    // R4 read-then-clear
    do_write(1'b0);
    chk("R4 write0 without read", rx_err, 1);
    do_read(rv);
    chk("R12 rdata err bit", rv, 2'b11);
    do_write(1'b1);
    chk("R4 write1 ignored", rx_err, 1);
    do_write(1'b0);
    chk("R4 arm consumed", rx_err, 1);
    do_read(rv);
    do_write(1'b0);
    chk("R4 read then write0 clears", rx_err, 0);

    // R3 bad second stop with flag clear
    par_en = 1'b0;
    send_char(8'h3C, 1'b0);
    send_stop(1'b1);
    chk("R3 clean commit", rxf_word, {2'b00, 8'h3C});
    send_stop(1'b0);
    chk("R3 second stop 0 ignored", rx_err, 0);
    chk("R3 second stop no write", rxf_wr, 0);

    // R5 set beats clear
    send_char(8'h11, 1'b0);
    send_stop(1'b0);
    chk("R1 framing sets", rx_err, 1);
    do_read(rv);
    send_char(8'h22, 1'b0);
    stop_stb = 1'b1; stop_bit = 1'b0; reg_wr = 1'b1; reg_wdata = 1'b0;
    tick();
    stop_stb = 1'b0; reg_wr = 1'b0;
    chk("R5 set wins", rx_err, 1);
    chk("R7 write with clear", rxf_wr, 1);
    do_read(rv);
    do_write(1'b0);
    chk("R4 clear again", rx_err, 0);

    // R6 receiver disabled
    rx_en = 1'b0;
    send_char(8'h44, 1'b0);
    send_stop(1'b0);
    chk("R6 disabled no write", rxf_wr, 0);
    chk("R6 disabled no error", rx_err, 0);
    rx_en = 1'b1;
    send_char(8'h45, 1'b0);
    send_stop(1'b0);
    rx_en = 1'b0;
    repeat (3) tick();
    chk("R6 flag kept when disabled", rx_err, 1);
    rx_en = 1'b1;

    // R9 standby discards arm
    do_read(rv);
    standby = 1'b1;
    tick();
    standby = 1'b0;
    chk("R9 standby clears err", rx_err, 0);
    chk("R9 standby sets tx_end", tx_end, 1);
    send_char(8'h46, 1'b0);
    send_stop(1'b0);
    do_write(1'b0);
    chk("R9 arm discarded", rx_err, 1);

    // R10 R11 transmit end
    txf_wr = 1'b1; tick(); txf_wr = 1'b0;
    chk("R11 fifo write clears", tx_end, 0);
    txf_empty = 1'b0; tx_last = 1'b1; tick(); tx_last = 1'b0;
    chk("R10 last bit not empty", tx_end, 0);
    txf_empty = 1'b1; tx_last = 1'b1; tick(); tx_last = 1'b0;
    chk("R10 last bit empty sets", tx_end, 1);
    txf_wr = 1'b1; tick(); txf_wr = 1'b0;
    chk("R11 clear again", tx_end, 0);
    tx_last = 1'b1; txf_wr = 1'b1; tick(); tx_last = 1'b0; txf_wr = 1'b0;
    chk("R11 set beats write", tx_end, 1);
    txf_wr = 1'b1; tick(); txf_wr = 1'b0;
    tx_en = 1'b0; tick();
    chk("R11 disable sets", tx_end, 1);
    txf_wr = 1'b1; tick(); txf_wr = 1'b0;
    chk("R11 disabled write ignored", tx_end, 1);
    tx_en = 1'b1;
    tick();
    chk("R12 rdata both", rdata, 2'b11);

    done = 1'b1;
    finish_run();
  end
endmodule